// File: doc/BRIEF.md
# Serial Memory Read Target on a Two-Wire Bus

This block is the read side of a byte-addressed serial memory that sits on a two-wire (I2C) bus as a target. It holds two internal byte stores. The main array has `2**MAIN_AW` bytes; the 32 KiB configuration uses `MAIN_AW = 15`. The second store is a separate identification page of `2**ID_AW` bytes, 64 by default. A load port fills both stores before bus traffic starts. SCL and SDA are sampled with the system clock through a synchronizer. The block pulls SDA low through an open-drain enable and never drives it high.

A controller addresses the block with a select byte. The upper four bits of this byte pick the store, the next three bits must equal the strap pins, and the last bit is the read/write flag. A write-flagged select is followed by two address bytes, high byte first. These load the single address counter that both stores share. The controller may then issue a repeated Start and a read-flagged select, which gives a random read. A read-flagged select straight after a Start returns data from wherever the counter already points. Each byte the controller acknowledges makes the block stream the next one. A not-acknowledge releases the bus.

Top module: `i2c_mem_reader`

## Requirements
- R1: While reset is asserted and after its release, `sda_oe_o` is 0 until a valid select byte has been received.
- R2: A select byte is acknowledged only if bits 7..4 equal 1010 (main array) or 1011 (identification page) and bits 3..1 equal `strap_i`. Bit 0 is the read flag (1 = read). A select byte that fails this test gets no acknowledge, and SDA is not driven again until the next Start.
- R3: A random read returns the byte at the loaded address. The sequence is a write-flagged select, a high address byte, a low address byte, a repeated Start with no Stop before it, and a read-flagged select. The main array takes the low `MAIN_AW` bits of {high, low}, so higher bits are ignored.
- R4: A read-flagged select directly after a Start returns the byte at the current counter value.
- R5: The counter advances by one for every byte the block sends. When the controller acknowledges a byte, the block sends the next consecutive byte.
- R6: After the controller does not acknowledge a byte, the block leaves SDA released on all further clocks until the next Start.
- R7: In the main array, the byte after address `2**MAIN_AW - 1` comes from address 0.
- R8: Type 1011 reads the identification page at address bits 5..0 and ignores all higher address bits. A current-address read of type 1011 uses the low six counter bits.
- R9: A sequential identification-page read that passes byte 63 continues with byte 0 of the page.
- R10: An identification-page access leaves the shared counter at the page position, advanced past the bytes sent. A following main-array current-address read starts from that value.
- R11: A Start or Stop at any point ends the transfer in progress and releases SDA. An address that was only partly transferred does not change the counter.
- R12: `sda_oe_o` is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Address strap compared with select bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| fill_en_i | input | 1 | Store-load write strobe |
| fill_id_i | input | 1 | 1 selects the identification page for loading |
| fill_addr_i | input | MAIN_AW | Load address (low ID_AW bits for the page) |
| fill_data_i | input | 8 | Load data byte |

## Verification
The bench builds the block with `MAIN_AW = 8` and the default `ID_AW = 6`. With a 256-byte main array, the whole high address byte lies above the used bits, so sending it as 0xFF shows that it is ignored. The rollover from 0xFF to 0x00 also comes within reach of a four-byte sequential read. The 64-byte page keeps its default size, so the wrap from byte 63 to 0 and the masking of address bits above bit 5 are tested at the real page boundary.

// File: rtl/i2cmr_pkg.sv
package i2cmr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_ACK,
        ST_TX,
        ST_MACK
    } state_e;

    // what follows the acknowledge slot the target is driving
    typedef enum logic [1:0] {
        NX_HI,
        NX_LO,
        NX_TX,
        NX_IDLE
    } after_ack_e;

    localparam logic [3:0] TYPE_MAIN = 4'b1010;
    localparam logic [3:0] TYPE_PAGE = 4'b1011;

endpackage

// File: rtl/i2cmr_sync.sv
module i2cmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_sr_q;
    logic [DEPTH-1:0] sda_sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
        end else begin
            scl_sr_q <= {scl_sr_q[DEPTH-2:0], scl_i};
            sda_sr_q <= {sda_sr_q[DEPTH-2:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sr_q[DEPTH-2];
    assign scl_old = scl_sr_q[DEPTH-1];
    assign sda_now = sda_sr_q[DEPTH-2];
    assign sda_old = sda_sr_q[DEPTH-1];

    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    // data edges while the clock stays high
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/i2cmr_mem.sv
module i2cmr_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader
    import i2cmr_pkg::*;
#(
    parameter int MAIN_AW     = 11,
    parameter int ID_AW       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [2:0]         strap_i,
    output logic               sda_oe_o,
    input  logic               fill_en_i,
    input  logic               fill_id_i,
    input  logic [MAIN_AW-1:0] fill_addr_i,
    input  logic [7:0]         fill_data_i
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        state_e             st;
        after_ack_e         nx;
        logic [CNT_W-1:0]   bcnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  hi;
        logic [MAIN_AW-1:0] ctr;
        logic               use_id;
        logic               oe;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, nx: NX_IDLE, bcnt: '0, sh: '0, hi: '0,
        ctr: '0, use_id: 1'b0, oe: 1'b0
    };

    regs_t q, d;

    // ---------------- bus sampling ----------------
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2cmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    // ---------------- byte stores ----------------
    logic [BYTE_W-1:0] main_byte, page_byte, tx_byte;

    i2cmr_mem #(.AW(MAIN_AW), .DW(BYTE_W)) u_main (
        .clk     (clk),
        .wr_en   (fill_en_i & ~fill_id_i),
        .wr_addr (fill_addr_i),
        .wr_data (fill_data_i),
        .rd_addr (q.ctr),
        .rd_data (main_byte)
    );

    i2cmr_mem #(.AW(ID_AW), .DW(BYTE_W)) u_page (
        .clk     (clk),
        .wr_en   (fill_en_i & fill_id_i),
        .wr_addr (fill_addr_i[ID_AW-1:0]),
        .wr_data (fill_data_i),
        .rd_addr (q.ctr[ID_AW-1:0]),
        .rd_data (page_byte)
    );

    assign tx_byte = q.use_id ? page_byte : main_byte;

    // ---------------- counter arithmetic ----------------
    logic [ID_AW-1:0]   page_next;
    logic [MAIN_AW-1:0] ctr_inc;
    logic               sel_hit;

    assign page_next = q.ctr[ID_AW-1:0] + 1'b1;
    assign ctr_inc   = q.use_id ? MAIN_AW'(page_next) : q.ctr + 1'b1;
    assign sel_hit   = ((q.sh[7:4] == TYPE_MAIN) || (q.sh[7:4] == TYPE_PAGE))
                       && (q.sh[3:1] == strap_i);

    // ---------------- next-state logic ----------------
    always_comb begin
        d = q;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st   = ST_DEVSEL;
            d.oe   = 1'b0;
            d.bcnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                end
                ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO: begin
                    if (scl_rise && q.bcnt != CNT_FULL) begin
                        d.sh   = {q.sh[BYTE_W-2:0], sda_s};
                        d.bcnt = q.bcnt + 1'b1;
                    end else if (scl_fall && q.bcnt == CNT_FULL) begin
                        d.bcnt = '0;
                        if (q.st == ST_DEVSEL) begin
                            if (sel_hit) begin
                                d.oe     = 1'b1;
                                d.st     = ST_ACK;
                                d.use_id = (q.sh[7:4] == TYPE_PAGE);
                                d.nx     = q.sh[0] ? NX_TX : NX_HI;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_ADDR_HI) begin
                            d.oe = 1'b1;
                            d.st = ST_ACK;
                            d.hi = q.sh;
                            d.nx = NX_LO;
                        end else begin
                            d.oe  = 1'b1;
                            d.st  = ST_ACK;
                            d.nx  = NX_IDLE;
                            d.ctr = q.use_id ? MAIN_AW'(q.sh[ID_AW-1:0])
                                             : MAIN_AW'({q.hi, q.sh});
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        unique case (q.nx)
                            NX_HI:  d.st = ST_ADDR_HI;
                            NX_LO:  d.st = ST_ADDR_LO;
                            NX_TX: begin
                                d.st   = ST_TX;
                                d.oe   = ~tx_byte[BYTE_W-1];
                                d.sh   = {tx_byte[BYTE_W-2:0], 1'b0};
                                d.bcnt = CNT_W'(1);
                                d.ctr  = ctr_inc;
                            end
                            default: d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bcnt == CNT_FULL) begin
                            d.oe = 1'b0;
                            d.st = ST_MACK;
                        end else begin
                            d.oe   = ~q.sh[BYTE_W-1];
                            d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            d.bcnt = q.bcnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            d.st = ST_IDLE;
                        end
                    end else if (scl_fall) begin
                        d.st   = ST_TX;
                        d.oe   = ~tx_byte[BYTE_W-1];
                        d.sh   = {tx_byte[BYTE_W-2:0], 1'b0};
                        d.bcnt = CNT_W'(1);
                        d.ctr  = ctr_inc;
                    end
                end
                default: begin
                    d.st = ST_IDLE;
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

endmodule

// File: rtl/i2c_mem_reader_chk.sv
module i2c_mem_reader_chk
    import i2cmr_pkg::*;
#(
    parameter int MAIN_AW = 11,
    parameter int ID_AW   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               oe_i,
    input state_e             st_i,
    input logic [MAIN_AW-1:0] ctr_i,
    input logic               use_id_i
);

    // R12: the pull-down only engages while the clock line is low
    p_pull_in_low_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_i) |-> !scl_i);

    // R6 / R1: no drive while waiting for a Start
    p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_IDLE) |-> !oe_i);

    // R11: a freshly started select phase never holds the line
    p_select_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_DEVSEL) |-> !oe_i);

    // R9: while streaming the page the counter stays inside the page
    p_page_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == ST_TX && use_id_i) |-> ((ctr_i >> ID_AW) == '0));

    // R5 / R7: each continued main-array byte moves the counter by one, wrapping
    p_main_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_i) == ST_MACK && st_i == ST_TX && !use_id_i)
            |-> (ctr_i == $past(ctr_i) + MAIN_AW'(1)));

endmodule

bind i2c_mem_reader i2c_mem_reader_chk #(
    .MAIN_AW (MAIN_AW),
    .ID_AW   (ID_AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .oe_i     (sda_oe_o),
    .st_i     (q.st),
    .ctr_i    (q.ctr),
    .use_id_i (q.use_id)
);

// File: tb/i2c_mem_reader_test.sv
module i2c_mem_reader_test;
    localparam int MAW = 8;
    localparam int IAW = 6;
    localparam int H   = 6;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic fill_en = 1'b0;
    logic fill_id = 1'b0;
    logic [MAW-1:0] fill_addr = '0;
    logic [7:0] fill_data = '0;

    int checks = 0;
    int errors = 0;
    int r12_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_mem_reader #(.MAIN_AW(MAW), .ID_AW(IAW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .strap_i     (STRAP),
        .sda_oe_o    (sda_oe),
        .fill_en_i   (fill_en),
        .fill_id_i   (fill_id),
        .fill_addr_i (fill_addr),
        .fill_data_i (fill_data)
    );

    function automatic logic [7:0] main_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] page_val(input int a);
        return 8'(((a * 5) & 255) ^ 8'hC3);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q[$];
    string      req_q[$];
    logic [7:0] mon_v;
    event       got_ev;

    task automatic expect_byte(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected byte", int'(mon_v), 0);
            end else begin
                logic [7:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(mon_v == e, r, int'(mon_v), int'(e));
            end
        end
    end

    // R12 at the pins: pull-down never starts while SCL is high
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (sda_oe && !prev && scl) r12_bad++;
            prev = sda_oe;
        end
    end

    // ---------------- bus controller model ----------------
    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitn(H);
        scl = 1'b1;   waitn(H);
        sda_m = 1'b0; waitn(H);
        scl = 1'b0;   waitn(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitn(H);
        scl = 1'b1;   waitn(H);
        sda_m = 1'b1; waitn(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;  waitn(H);
        scl = 1'b1; waitn(H);
        scl = 1'b0; waitn(H);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; waitn(H);
        scl = 1'b1;   waitn(H / 2);
        b = sda_line; waitn(H - H / 2);
        scl = 1'b0;   waitn(H);
    endtask

    task automatic put_byte(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic get_byte(input bit ctl_ack);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!ctl_ack);
        mon_v = v;
        ->got_ev;
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) get_byte(i != n - 1);
    endtask

    task automatic select(input logic [3:0] ty, input logic rd, input string req);
        bit ak;
        put_byte({ty, STRAP, rd}, ak);
        check(ak, req, int'(ak), 1);
    endtask

    // dummy write of a two-byte address, then repeated Start and read select
    task automatic rand_setup(input logic [3:0] ty, input logic [7:0] hi, input logic [7:0] lo);
        bit ak;
        bus_start();
        select(ty, 1'b0, "R2 write select ack");
        put_byte(hi, ak); check(ak, "R3 high address ack", int'(ak), 1);
        put_byte(lo, ak); check(ak, "R3 low address ack", int'(ak), 1);
        bus_start();
        select(ty, 1'b1, "R3 read select ack");
    endtask

    task automatic idle_clocks(input string req);
        logic b;
        int hi_cnt;
        hi_cnt = 0;
        for (int i = 0; i < 9; i++) begin
            get_bit(b);
            if (b) hi_cnt++;
        end
        check(hi_cnt == 9, req, hi_cnt, 9);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit ak;
        // preload both stores during reset
        for (int a = 0; a < (1 << MAW); a++) begin
            @(negedge clk);
            fill_en = 1'b1; fill_id = 1'b0;
            fill_addr = MAW'(a); fill_data = main_val(a);
        end
        for (int a = 0; a < (1 << IAW); a++) begin
            @(negedge clk);
            fill_en = 1'b1; fill_id = 1'b1;
            fill_addr = MAW'(a); fill_data = page_val(a);
        end
        @(negedge clk);
        fill_en = 1'b0;
        check(sda_oe == 1'b0, "R1 released in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        waitn(10);
        check(sda_oe == 1'b0, "R1 released after reset", int'(sda_oe), 0);

        // R2: strap mismatch and wrong type are not acknowledged
        bus_start();
        put_byte({4'b1010, 3'b000, 1'b1}, ak);
        check(!ak, "R2 strap mismatch no ack", int'(ak), 0);
        idle_clocks("R2 no drive after rejected select");
        bus_stop();
        bus_start();
        put_byte({4'b1001, STRAP, 1'b1}, ak);
        check(!ak, "R2 wrong type no ack", int'(ak), 0);
        bus_stop();

        // R3: random read, high byte beyond the array ignored
        expect_byte(main_val(8'h10), "R3 random read");
        rand_setup(4'b1010, 8'hFF, 8'h10);
        read_n(1);
        bus_stop();

        // R4: current-address read continues after 0x10
        expect_byte(main_val(8'h11), "R4 current read");
        bus_start();
        select(4'b1010, 1'b1, "R4 select ack");
        read_n(1);
        bus_stop();

        // R5 / R7: sequential stream through the top of the array
        expect_byte(main_val(8'hFD), "R5 sequential first");
        expect_byte(main_val(8'hFE), "R5 sequential second");
        expect_byte(main_val(8'hFF), "R7 last address");
        expect_byte(main_val(8'h00), "R7 rollover to 0");
        rand_setup(4'b1010, 8'h00, 8'hFD);
        read_n(4);
        idle_clocks("R6 released after not-acknowledge");
        bus_stop();

        // R8: page read, address bits above 5 ignored
        expect_byte(page_val(5), "R8 page byte 5");
        expect_byte(page_val(6), "R8 page byte 6");
        rand_setup(4'b1011, 8'hAB, 8'hC5);
        read_n(2);
        bus_stop();

        // R9: page wrap 63 -> 0
        expect_byte(page_val(62), "R9 page byte 62");
        expect_byte(page_val(63), "R9 page byte 63");
        expect_byte(page_val(0), "R9 page wraps to 0");
        rand_setup(4'b1011, 8'h00, 8'h3E);
        read_n(3);
        bus_stop();

        // R10: shared counter now 1
        expect_byte(main_val(1), "R10 main after page access");
        bus_start();
        select(4'b1010, 1'b1, "R10 select ack");
        read_n(1);
        bus_stop();

        // R11: restart mid-address leaves counter at 2
        expect_byte(main_val(2), "R11 abort by Start keeps counter");
        bus_start();
        select(4'b1010, 1'b0, "R11 write select ack");
        put_byte(8'h00, ak);
        check(ak, "R11 high address ack", int'(ak), 1);
        bus_start();
        select(4'b1010, 1'b1, "R11 read select ack");
        read_n(1);
        bus_stop();

        // R11: Stop mid-address, counter now 3
        bus_start();
        select(4'b1010, 1'b0, "R11 write select ack");
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        check(sda_oe == 1'b0, "R11 released mid byte", int'(sda_oe), 0);
        bus_stop();
        check(sda_oe == 1'b0, "R11 released after Stop", int'(sda_oe), 0);
        expect_byte(main_val(3), "R11 abort by Stop keeps counter");
        bus_start();
        select(4'b1010, 1'b1, "R11 select ack");
        read_n(1);
        bus_stop();

        // R8: page current read uses low counter bits (4); R10 main then at 5
        expect_byte(page_val(4), "R8 page current read");
        bus_start();
        select(4'b1011, 1'b1, "R8 select ack");
        read_n(1);
        bus_stop();
        expect_byte(main_val(5), "R10 main follows page counter");
        bus_start();
        select(4'b1010, 1'b1, "R10 select ack");
        read_n(1);
        bus_stop();

        waitn(4);
        check(exp_q.size() == 0, "R5 all expected bytes seen", exp_q.size(), 0);
        check(r12_bad == 0, "R12 pull-down only with SCL low", r12_bad, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            repeat (150000) @(posedge clk);
        join_any
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule